// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM. A host raises chip select, clocks in a start bit, a two-bit opcode and an address on data-in, and then either streams data out or supplies a data word to be programmed. The array lives in on-chip registers. A strap input picks how the array is viewed: 64 words of 16 bits or 128 words of 8 bits. Both views cover the same 128 bytes.

Programming commands only take effect after an enable command. Each one starts a self-timed cycle when chip select falls, and it needs no further serial clocks. While that cycle runs, data-out reports busy, and it reports ready once the cycle ends. Reads stream consecutive words for as long as chip select stays high, and the address wraps at the top of the array.

The serial pins are synchronized into the system clock domain, and edges are detected there. The tri-state data-out pin is modelled as a data output plus an output-enable.

Top module: `serial_eeprom3w`

## Requirements
- R1: After reset, programming is disabled, every byte of the array holds 8'hFF, and `dout_oe` is low.
- R2: With `org16` high, a frame is a start bit (1), two opcode bits and a 6-bit word address, and words are 16 bits. With `org16` low, the address is 7 bits and words are 8 bits. The 16-bit word at address a consists of the 8-bit byte at address 2a (upper half) and the byte at 2a+1 (lower half).
- R3: The opcodes are 10 for read, 01 for write and 11 for erase. Opcode 00 uses the two top address bits as a sub-code: 11 enables programming, 00 disables it, 10 erases the whole array and 01 writes the whole array.
- R4: While programming is disabled, write, erase, erase-all and write-all leave the array unchanged and start no busy cycle.
- R5: Read works in either protection state. After the last address bit, data-out gives a single 0, then the word MSB first, one bit per serial clock rising edge.
- R6: While chip select stays high, a read continues with the next address after each word. The address wraps from the last word to word 0.
- R7: Write stores the received word with no prior erase. Erase sets the addressed word to all ones.
- R8: Erase-all sets every word to all ones. Write-all copies the received word into every word.
- R9: A program command starts when chip select falls after the full frame. For PROG_CYCLES system clocks, data-out is low while chip select is high. It then goes high and stays high while chip select is high.
- R10: A command framed while a program cycle runs has no effect.
- R11: Data-in low on serial clock rising edges before the start bit is skipped, and the frame begins at the first 1.
- R12: `dout_oe` is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data-in, sampled on serial clock rising edges |
| org16 | input | 1 | Organization strap: 1 selects 64x16, 0 selects 128x8 |
| dout | output | 1 | Serial data-out or busy/ready flag |
| dout_oe | output | 1 | Output enable for data-out; low means high-impedance |

## Verification
A wrong bit counter or a mis-decoded opcode shows up on the first read-back of an address that was just programmed. A slipped frame produces a word that is shifted by one bit, which is visible within a single command. A faulty protection latch makes a write land while programming is disabled, or makes a busy low appear on data-out, within a few clocks after chip select falls. A broken busy counter shows up at the ready edge, which must arrive within a narrow window of PROG_CYCLES. An address counter that does not wrap is exposed by the third word of a stream that starts two words below the top of the array.

// File: rtl/serial_eeprom3w.sv
module serial_eeprom3w #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  input  logic org16,
  output logic dout,
  output logic dout_oe
);
  localparam int NBYTES = 128;
  localparam int CW = $clog2(PROG_CYCLES);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD, S_BUSY} st_t;
  typedef enum logic [2:0] {K_NONE, K_WR, K_ER, K_WRAL, K_ERAL} job_t;

  logic cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s;
  st_t st;
  job_t job;
  logic [4:0] bcnt;
  logic [7:0] sr;
  logic [15:0] wsr, rsr;
  logic [6:0] addr;
  logic wen, dout_r, rdy;
  logic [CW-1:0] bsy_cnt;
  logic [7:0] mem [NBYTES];

  wire sk_rise = sk_s & ~sk_d;
  wire cs_fall = cs_d & ~cs_s;
  wire [8:0] nxt = {sr, di_s};
  wire [1:0] dec_op = org16 ? nxt[7:6] : nxt[8:7];
  wire [6:0] dec_a = org16 ? {1'b0, nxt[5:0]} : nxt[6:0];
  wire [1:0] dec_sp = org16 ? nxt[5:4] : nxt[6:5];
  wire last_cmd = bcnt == (org16 ? 5'd7 : 5'd8);
  wire last_word = bcnt == (org16 ? 5'd15 : 5'd7);
  wire [6:0] addr_inc = org16 ? {1'b0, addr[5:0] + 6'd1} : addr + 7'd1;

  wire busy = st == S_BUSY;
  wire rd_act = st == S_READ;

  assign dout_oe = cs_s & (rd_act | busy | rdy);
  assign dout = rd_act ? dout_r : ~busy;

  function automatic logic [15:0] fetch(input logic [6:0] a);
    fetch = org16 ? {mem[{a[5:0], 1'b0}], mem[{a[5:0], 1'b1}]} : {mem[a], 8'h00};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s} <= '0;
    end else begin
      cs_m <= cs;   cs_s <= cs_m;   cs_d <= cs_s;
      sk_m <= sclk; sk_s <= sk_m;   sk_d <= sk_s;
      di_m <= din;  di_s <= di_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      job <= K_NONE;
      bcnt <= '0;
      sr <= '0;
      wsr <= '0;
      rsr <= '0;
      addr <= '0;
      wen <= 1'b0;
      dout_r <= 1'b0;
      rdy <= 1'b0;
      bsy_cnt <= '0;
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else begin
      case (st)
        S_IDLE:
          if (cs_s && sk_rise && di_s) begin
            st <= S_CMD;
            bcnt <= '0;
            sr <= '0;
            rdy <= 1'b0;
          end
        S_CMD:
          if (sk_rise) begin
            sr <= nxt[7:0];
            bcnt <= bcnt + 5'd1;
            if (last_cmd) begin
              addr <= dec_a;
              bcnt <= '0;
              job <= K_NONE;
              st <= S_HOLD;
              case (dec_op)
                2'b10: begin
                  st <= S_READ;
                  dout_r <= 1'b0;
                  rsr <= fetch(dec_a);
                end
                2'b01: begin
                  st <= S_DATA;
                  job <= K_WR;
                end
                2'b11: job <= K_ER;
                default:
                  case (dec_sp)
                    2'b11: wen <= 1'b1;
                    2'b00: wen <= 1'b0;
                    2'b10: job <= K_ERAL;
                    default: begin
                      st <= S_DATA;
                      job <= K_WRAL;
                    end
                  endcase
              endcase
            end
          end
        S_DATA:
          if (sk_rise) begin
            wsr <= {wsr[14:0], di_s};
            bcnt <= bcnt + 5'd1;
            if (last_word) st <= S_HOLD;
          end
        S_READ:
          if (sk_rise) begin
            dout_r <= rsr[15];
            rsr <= {rsr[14:0], 1'b0};
            bcnt <= bcnt + 5'd1;
            if (last_word) begin
              bcnt <= '0;
              addr <= addr_inc;
              rsr <= fetch(addr_inc);
            end
          end
        S_BUSY:
          if (bsy_cnt == '0) begin
            st <= S_IDLE;
            rdy <= 1'b1;
          end else begin
            bsy_cnt <= bsy_cnt - 1'b1;
          end
        default: ;
      endcase

      if (cs_fall && st != S_BUSY) begin
        st <= S_IDLE;
        rdy <= 1'b0;
        job <= K_NONE;
        if (st == S_HOLD && job != K_NONE && wen) begin
          st <= S_BUSY;
          bsy_cnt <= CW'(PROG_CYCLES - 1);
          case (job)
            K_WR, K_ER:
              if (org16) begin
                mem[{addr[5:0], 1'b0}] <= (job == K_WR) ? wsr[15:8] : 8'hFF;
                mem[{addr[5:0], 1'b1}] <= (job == K_WR) ? wsr[7:0] : 8'hFF;
              end else begin
                mem[addr] <= (job == K_WR) ? wsr[7:0] : 8'hFF;
              end
            K_WRAL:
              for (int i = 0; i < NBYTES; i++)
                mem[i] <= (org16 && !i[0]) ? wsr[15:8] : wsr[7:0];
            default:
              for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_eeprom3w_chk.sv
module serial_eeprom3w_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_oe,
  input logic busy,
  input logic rd_act,
  input logic wen
);
  localparam int LW = $clog2(PROG_CYCLES + 1);
  logic [LW-1:0] blen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) blen <= '0;
    else blen <= busy ? blen + 1'b1 : '0;

  p_quiet_cs_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs, 2) |-> !dout_oe);

  p_busy_drives_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(cs, 2) |-> dout_oe && !dout);

  p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> blen < LW'(PROG_CYCLES));

  p_busy_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(blen) == LW'(PROG_CYCLES - 1));

  p_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  p_dummy_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> !dout);
endmodule

bind serial_eeprom3w serial_eeprom3w_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_oe(dout_oe),
  .busy(busy), .rd_act(rd_act), .wen(wen)
);

// File: tb/tb_serial_eeprom3w.sv
module tb_serial_eeprom3w;
  localparam int PROG = 600;
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {6'd0, 16'h1234}, {6'd1, 16'hA5F0}, {6'd7, 16'h0001},
    {6'd33, 16'h8000}, {6'd62, 16'hC0DE}, {6'd20, 16'h7E81}
  };

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, din = 0, org16 = 1;
  logic dout, dout_oe;
  int checks = 0, errors = 0;

  serial_eeprom3w #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
    .org16(org16), .dout(dout), .dout_oe(dout_oe)
  );

  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic o);
    sclk = 0; din = b; tick(4);
    sclk = 1; tick(4);
    o = dout;
  endtask

  task automatic open_cs();
    cs = 1; tick(4);
  endtask

  task automatic close_cs();
    sclk = 0; din = 0; tick(4);
    cs = 0; tick(6);
  endtask

  function automatic int aw();
    return org16 ? 6 : 7;
  endfunction

  function automatic int ww();
    return org16 ? 16 : 8;
  endfunction

  task automatic frame(input logic [1:0] op, input logic [6:0] a, output logic last);
    logic o;
    xbit(1'b1, o); xbit(op[1], o); xbit(op[0], o);
    for (int i = aw() - 1; i >= 0; i--) xbit(a[i], o);
    last = o;
  endtask

  task automatic send_word(input logic [15:0] d);
    logic o;
    for (int i = ww() - 1; i >= 0; i--) xbit(d[i], o);
  endtask

  task automatic get_word(output logic [15:0] d);
    logic o;
    d = '0;
    for (int i = 0; i < ww(); i++) begin
      xbit(1'b0, o);
      d = {d[14:0], o};
    end
  endtask

  function automatic logic [6:0] sp(input logic [1:0] s);
    return org16 ? {1'b0, s, 4'b0} : {s, 5'b0};
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d, input logic with_data);
    logic o;
    open_cs();
    frame(op, a, o);
    if (with_data) send_word(d);
    close_cs();
  endtask

  task automatic wait_ready(output int n);
    cs = 1; n = 0;
    tick(1);
    while (!(dout_oe && dout) && n < 3 * PROG) begin
      tick(1); n++;
    end
    close_cs();
  endtask

  task automatic read1(input logic [6:0] a, output logic [15:0] d, output logic dummy);
    open_cs();
    frame(2'b10, a, dummy);
    get_word(d);
    close_cs();
  endtask

  task automatic prog_ok(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d, input logic wd, input string req);
    int n;
    cmd(op, a, d, wd);
    wait_ready(n);
    check(n >= PROG - 16 && n <= PROG + 16, req, n, PROG);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic dm, o;
    int n;
    tick(10);
    rst_n = 1;
    tick(4);
    check(dout_oe == 0, "R1 oe after reset", dout_oe, 0);
    read1(7'd0, d, dm);
    check(d == 16'hFFFF, "R1 array ones", d, 16'hFFFF);
    check(dm == 0, "R5 dummy bit", dm, 0);

    cmd(2'b01, 7'd5, 16'h1234, 1);
    open_cs(); tick(8);
    check(dout_oe == 0, "R4 no busy when disabled", dout_oe, 0);
    close_cs();
    read1(7'd5, d, dm);
    check(d == 16'hFFFF, "R4 write blocked", d, 16'hFFFF);

    cmd(2'b00, sp(2'b11), 16'h0, 0);
    for (int i = 0; i < NV; i++)
      prog_ok(2'b01, {1'b0, VEC[i][21:16]}, VEC[i][15:0], 1, "R9 ready timing");
    for (int i = 0; i < NV; i++) begin
      read1({1'b0, VEC[i][21:16]}, d, dm);
      check(d == VEC[i][15:0], "R7 write readback", d, VEC[i][15:0]);
    end

    cmd(2'b01, 7'd10, 16'hAAAA, 1);
    cs = 1; tick(8);
    check(dout_oe && !dout, "R9 busy low", {dout_oe, dout}, 2'b10);
    tick(300);
    check(dout_oe && !dout, "R9 still busy", {dout_oe, dout}, 2'b10);
    cs = 0; tick(4);
    check(dout_oe == 0, "R12 oe off with cs low", dout_oe, 0);
    cmd(2'b01, 7'd11, 16'h5555, 1);
    wait_ready(n);
    check(n < 3 * PROG, "R9 ready reached", n, 0);
    read1(7'd11, d, dm);
    check(d == 16'hFFFF, "R10 ignored while busy", d, 16'hFFFF);
    read1(7'd10, d, dm);
    check(d == 16'hAAAA, "R7 word 10", d, 16'hAAAA);

    prog_ok(2'b01, 7'd63, 16'hBEEF, 1, "R9 ready timing");
    open_cs();
    frame(2'b10, 7'd62, dm);
    get_word(d);
    check(d == 16'hC0DE, "R6 stream word 62", d, 16'hC0DE);
    get_word(d);
    check(d == 16'hBEEF, "R6 stream word 63", d, 16'hBEEF);
    get_word(d);
    check(d == 16'h1234, "R6 wrap to 0", d, 16'h1234);
    close_cs();

    prog_ok(2'b11, 7'd63, 16'h0, 0, "R9 ready timing");
    read1(7'd63, d, dm);
    check(d == 16'hFFFF, "R7 erase word", d, 16'hFFFF);

    open_cs();
    xbit(1'b0, o); xbit(1'b0, o); xbit(1'b0, o);
    frame(2'b10, 7'd1, dm);
    get_word(d);
    close_cs();
    check(d == 16'hA5F0, "R11 leading zeros", d, 16'hA5F0);

    org16 = 0; tick(4);
    read1(7'd2, d, dm);
    check(d[7:0] == 8'hA5, "R2 x8 upper byte", d[7:0], 8'hA5);
    read1(7'd3, d, dm);
    check(d[7:0] == 8'hF0, "R2 x8 lower byte", d[7:0], 8'hF0);
    prog_ok(2'b01, 7'd21, 16'h003C, 1, "R9 ready timing");
    org16 = 1; tick(4);
    read1(7'd10, d, dm);
    check(d == 16'hAA3C, "R2 x8 write in x16 view", d, 16'hAA3C);

    cmd(2'b00, sp(2'b00), 16'h0, 0);
    cmd(2'b11, 7'd0, 16'h0, 0);
    open_cs(); tick(8);
    check(dout_oe == 0, "R3 disable stops erase", dout_oe, 0);
    close_cs();
    read1(7'd0, d, dm);
    check(d == 16'h1234, "R4 erase blocked", d, 16'h1234);
    check(dm == 0, "R5 read while disabled", dm, 0);
    cmd(2'b00, sp(2'b10), 16'h0, 0);
    read1(7'd1, d, dm);
    check(d == 16'hA5F0, "R4 erase-all blocked", d, 16'hA5F0);

    cmd(2'b00, sp(2'b11), 16'h0, 0);
    prog_ok(2'b00, sp(2'b10), 16'h0, 0, "R9 ready timing");
    read1(7'd33, d, dm);
    check(d == 16'hFFFF, "R8 erase-all", d, 16'hFFFF);
    prog_ok(2'b00, sp(2'b01), 16'h5AC3, 1, "R9 ready timing");
    read1(7'd0, d, dm);
    check(d == 16'h5AC3, "R8 write-all word 0", d, 16'h5AC3);
    read1(7'd40, d, dm);
    check(d == 16'h5AC3, "R8 write-all word 40", d, 16'h5AC3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule